// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host read and write an external asynchronous static RAM of 8,192 bytes. The host presents an address, a direction bit and, for writes, a data byte, and raises a request. The request is taken in a cycle where the controller reports ready. The controller then steps the memory's chip enables, write strobe and output enable through a fixed sequence. Each step lasts a whole number of clock cycles. The step lengths come from nanosecond limits and a clock-period parameter, so the part's access, pulse-width, setup and float times are met at any clock rate.

The memory data bus is split into an output byte, a driver-enable for the tristate buffer and an input byte. Two chip enables of opposite polarity are driven together. Both are deasserted whenever the controller is idle, so the memory sits in standby between accesses. A read ends with a single-cycle valid strobe carrying the captured byte. A write waits for the memory's outputs to float before it drives the bus. It also keeps driving data for one cycle after the write strobe rises.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever idle: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dout_en`=0, `host_ready`=1, `host_rvalid`=0.
- R2: `host_ready` is high only while idle. A request is taken at a rising edge where `host_req` and `host_ready` are both 1. `host_ready` falls in the next cycle. A request raised while `host_ready` is 0 starts nothing and changes no memory pin.
- R3: Address, direction (`host_write`=1 means write) and write data are registered when the request is taken. `mem_addr` equals the taken address and stays constant while a chip enable is active. `mem_dout` equals the taken data whenever the driver is on. Host input changes during an access have no effect.
- R4: A read holds `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dout_en`=0 for exactly RD cycles. RD = max(1, ceil(T_READ_NS/CLK_PERIOD_NS), ceil(T_CYCLE_NS/CLK_PERIOD_NS)), which is 14 at the defaults.
- R5: `mem_din` is sampled on the last read cycle. In the following cycle it appears on `host_rdata` with `host_rvalid`=1 for exactly one cycle, together with `host_ready`=1 and all chip enables released.
- R6: A write first holds the chip enabled with `mem_oe_n`=1, `mem_we_n`=1 and `mem_dout_en`=0 for TA cycles. TA = max(1, ceil(T_HIZ_NS/CLK_PERIOD_NS)), which is 6 at the defaults.
- R7: The write pulse then holds `mem_we_n`=0 and `mem_dout_en`=1, with `mem_dout` unchanged, for WP cycles. WP is the largest of the pulse-width count, the data-setup count and the minimum-cycle count minus TA minus 1, and at least 1. It is 10 at the defaults.
- R8: After the pulse there is one cycle with `mem_we_n`=1 while the driver and chip enables stay on. The controller then returns to idle with the driver off.
- R9: `mem_dout_en` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Host word address |
| host_wdata | input | 8 | Host write data |
| host_ready | output | 1 | Controller idle, request may be taken |
| host_rdata | output | 8 | Captured read data |
| host_rvalid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 13 | Memory address |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | 8 | Data to the memory bus |
| mem_dout_en | output | 1 | Tristate driver enable for `mem_dout` |
| mem_din | input | 8 | Data from the memory bus |

## Verification
Every memory pin is registered, so a wrong sequencer state or a wrong phase counter value shows on a strobe in the very next cycle. A miscounted phase therefore moves a strobe edge by one cycle, and the per-cycle pin comparison reports it where it happens. A corrupted address or data register shows at once on `mem_addr` or `mem_dout`. A lost or mistimed write shows later, as a wrong byte on the next read-back of that address. A capture on the wrong cycle returns the bench memory's float pattern instead of stored data.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_PULSE,
        ST_HOLD
    } phase_e;

    // Whole cycles covering t_ns at a period of p_ns, never below one.
    function automatic int unsigned cyc_of(input int unsigned t_ns, input int unsigned p_ns);
        int unsigned c;
        c = (t_ns + p_ns - 1) / p_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        data_d = capture ? din : data_q;
        vld_d  = capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata  = data_q;
    assign rvalid = vld_q;
endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_READ_NS     = 70,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_HIZ_NS      = 30,
    parameter int T_WP_NS       = 50,
    parameter int T_DSETUP_NS   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    // Phase lengths in clock cycles.
    localparam int unsigned CYC_MIN    = cyc_of(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned READ_CYC   = max2(cyc_of(T_READ_NS, CLK_PERIOD_NS), CYC_MIN);
    localparam int unsigned TURN_CYC   = cyc_of(T_HIZ_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_BASE = max2(cyc_of(T_WP_NS, CLK_PERIOD_NS),
                                              cyc_of(T_DSETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned PULSE_CYC  = (CYC_MIN > TURN_CYC + 1 + PULSE_BASE)
                                         ? (CYC_MIN - TURN_CYC - 1) : PULSE_BASE;
    localparam int unsigned MAX_CYC    = max2(READ_CYC, max2(TURN_CYC, PULSE_CYC));
    localparam int          CNT_W      = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              cs;
        logic              we_n;
        logic              oe_n;
        logic              drv;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_en;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (ctl_q.phase)
            ST_IDLE: begin
                if (host_req) begin
                    ctl_d.addr = host_addr;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.cs   = 1'b1;
                    tmr_load   = 1'b1;
                    if (host_write) begin
                        ctl_d.phase = ST_TURN;
                        ctl_d.wdata = host_wdata;
                        tmr_val     = TURN_LD;
                    end else begin
                        ctl_d.phase = ST_READ;
                        ctl_d.oe_n  = 1'b0;
                        tmr_val     = READ_LD;
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    cap_en      = 1'b1;
                    ctl_d.phase = ST_IDLE;
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.cs    = 1'b0;
                    ctl_d.oe_n  = 1'b1;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    ctl_d.phase = ST_PULSE;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.drv   = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = PULSE_LD;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    ctl_d.phase = ST_HOLD;
                    ctl_d.we_n  = 1'b1;
                end
            end
            ST_HOLD: begin
                ctl_d.phase = ST_IDLE;
                ctl_d.drv   = 1'b0;
                ctl_d.cs_n  = 1'b1;
                ctl_d.cs    = 1'b0;
            end
            default: begin
                ctl_d.phase = ST_IDLE;
                ctl_d.cs_n  = 1'b1;
                ctl_d.cs    = 1'b0;
                ctl_d.we_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.drv   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.wdata <= '0;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.cs    <= 1'b0;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.drv   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .din     (mem_din),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    assign host_ready  = (ctl_q.phase == ST_IDLE);
    assign mem_addr    = ctl_q.addr;
    assign mem_cs_n    = ctl_q.cs_n;
    assign mem_cs      = ctl_q.cs;
    assign mem_we_n    = ctl_q.we_n;
    assign mem_oe_n    = ctl_q.oe_n;
    assign mem_dout    = ctl_q.wdata;
    assign mem_dout_en = ctl_q.drv;
endmodule

// File: rtl/sram_async_ctl_chk.sv
`timescale 1ns/1ps
module sram_async_ctl_chk #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    // Cycles spent with the chip enabled before the data driver turns on.
    logic [15:0] turn_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            turn_cnt_q <= '0;
        else if (mem_cs_n)     turn_cnt_q <= '0;
        else if (!mem_dout_en) turn_cnt_q <= turn_cnt_q + 16'd1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dout_en));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> !host_ready);

    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_read_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

    p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    p_rvalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (host_ready && mem_cs_n));

    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (turn_cnt_q == 16'(TURN_CYC)));

    p_pulse_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dout_en && !mem_cs_n && mem_cs && mem_oe_n));

    p_pulse_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dout));

    p_write_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dout_en && !mem_cs_n));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dout_en) |-> (mem_cs_n && $past(mem_we_n)));

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_cs      (mem_cs),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;
    localparam int P     = 5;
    localparam int WORDS = 8192;

    function automatic int cdiv(input int t, input int p);
        int c;
        c = (t + p - 1) / p;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Phase lengths from the requirements (R4, R6, R7).
    localparam int RD_N    = imax(cdiv(70, P), cdiv(70, P));
    localparam int TA_N    = cdiv(30, P);
    localparam int WP_BASE = imax(cdiv(50, P), cdiv(30, P));
    localparam int WP_N    = imax(WP_BASE, cdiv(70, P) - TA_N - 1);

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_req, host_write;
    logic [12:0] host_addr;
    logic [7:0]  host_wdata;
    logic       host_ready, host_rvalid;
    logic [7:0] host_rdata;
    logic [12:0] mem_addr;
    logic       mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dout_en;
    logic [7:0] mem_dout, mem_din;

    always #2.5 clk = ~clk;

    sram_async_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    // Behavioural memory device; drives 8'hEE when its outputs float.
    logic [7:0] dev [WORDS];
    logic [7:0] shadow [WORDS];
    assign mem_din = (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n) ? dev[mem_addr] : 8'hEE;
    always @(posedge mem_we_n)
        if (rst_n === 1'b1 && !mem_cs_n && mem_cs && mem_dout_en)
            dev[mem_addr] = mem_dout;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input int r, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // Expected per-cycle pin picture; tag is the requirement the cycle belongs to.
    typedef struct packed {
        logic cs_n, cs, we_n, oe_n, drv, rdy, rv;
        logic [3:0] tag;
    } exp_t;

    function automatic exp_t mk(input logic cs_n, cs, we_n, oe_n, drv, rdy, rv, input int t);
        exp_t e;
        e.cs_n = cs_n; e.cs = cs; e.we_n = we_n; e.oe_n = oe_n;
        e.drv = drv; e.rdy = rdy; e.rv = rv; e.tag = 4'(t);
        return e;
    endfunction

    exp_t       exp_q[$];
    exp_t       cur;
    logic [12:0] acc_addr;
    logic [7:0]  acc_data;
    logic [7:0]  exp_rdata;

    // Reference timeline: R1 idle, R4 read, R5 return, R6 turnaround, R7 pulse, R8 hold.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q.delete();
            cur = mk(1, 0, 1, 1, 0, 1, 0, 1);
        end else begin
            if (cur.rdy && host_req) begin
                acc_addr = host_addr;
                if (host_write) begin
                    acc_data = host_wdata;
                    shadow[host_addr] = host_wdata;
                    for (int i = 0; i < TA_N; i++) exp_q.push_back(mk(0, 1, 1, 1, 0, 0, 0, 6));
                    for (int i = 0; i < WP_N; i++) exp_q.push_back(mk(0, 1, 0, 1, 1, 0, 0, 7));
                    exp_q.push_back(mk(0, 1, 1, 1, 1, 0, 0, 8));
                end else begin
                    exp_rdata = shadow[host_addr];
                    for (int i = 0; i < RD_N; i++) exp_q.push_back(mk(0, 1, 1, 0, 0, 0, 0, 4));
                    exp_q.push_back(mk(1, 0, 1, 1, 0, 1, 1, 5));
                end
            end
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else                  cur = mk(1, 0, 1, 1, 0, 1, 0, 1);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk(mem_cs_n == cur.cs_n, cur.tag, "mem_cs_n", mem_cs_n, cur.cs_n);
            chk(mem_cs   == cur.cs,   cur.tag, "mem_cs",   mem_cs,   cur.cs);
            chk(mem_we_n == cur.we_n, cur.tag, "mem_we_n", mem_we_n, cur.we_n);
            chk(mem_oe_n == cur.oe_n, cur.tag, "mem_oe_n", mem_oe_n, cur.oe_n);
            chk(mem_dout_en == cur.drv, (cur.drv || cur.tag == 4'd8) ? cur.tag : 9,
                "mem_dout_en", mem_dout_en, cur.drv);
            chk(host_ready == cur.rdy, 2, "host_ready", host_ready, cur.rdy);      // R2
            chk(host_rvalid == cur.rv, 5, "host_rvalid", host_rvalid, cur.rv);    // R5
            if (!cur.cs_n)
                chk(mem_addr == acc_addr, 3, "mem_addr", mem_addr, acc_addr);     // R3
            if (cur.drv)
                chk(mem_dout == acc_data, 3, "mem_dout", mem_dout, acc_data);     // R3
            if (cur.rv)
                chk(host_rdata == exp_rdata, 5, "host_rdata", host_rdata, exp_rdata); // R5
        end
    end

    // One access; 'now' requests in the very cycle the previous access returns.
    task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                          input bit poke, input bit now);
        if (!now) @(negedge clk);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        // R3: scramble host inputs while busy.
        host_req = 1'b0; host_write = ~wr; host_addr = ~a; host_wdata = ~d;
        if (poke) begin
            // R2: request while not ready must be ignored.
            host_req = 1'b1;
            @(negedge clk);
            host_req = 1'b0;
        end
        while (!host_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            dev[i]    = 8'((i * 37) + 11);
            shadow[i] = 8'((i * 37) + 11);
        end
        rst_n = 1'b0; host_req = 1'b0; host_write = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(host_ready && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dout_en && !host_rvalid,
            1, "reset pins", {host_ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dout_en, host_rvalid},
            7'b1101100);
        repeat (3) @(negedge clk);

        access(1'b0, 13'h0000, 8'h00, 1'b0, 1'b0);   // R4 R5 read preloaded low end
        access(1'b0, 13'h1FFF, 8'h00, 1'b0, 1'b0);   // R4 R5 read preloaded top end
        access(1'b1, 13'h1FFF, 8'hA5, 1'b0, 1'b0);   // R6 R7 R8 write top end
        access(1'b0, 13'h1FFF, 8'h00, 1'b0, 1'b0);   // R5 read back
        access(1'b1, 13'h0000, 8'h5A, 1'b1, 1'b0);   // R2 busy request during write
        access(1'b0, 13'h0000, 8'h00, 1'b1, 1'b0);   // R2 busy request during read
        access(1'b1, 13'h1555, 8'h00, 1'b0, 1'b1);   // back-to-back after read
        access(1'b1, 13'h0AAA, 8'hFF, 1'b0, 1'b1);   // back-to-back write after write
        access(1'b0, 13'h1555, 8'h00, 1'b0, 1'b1);   // read after write, no gap
        access(1'b0, 13'h0AAA, 8'h00, 1'b0, 1'b1);
        access(1'b0, 13'h0123, 8'h00, 1'b0, 1'b0);   // untouched location
        for (int k = 0; k < 6; k++)
            access(1'b1, 13'(k * 1111), 8'(k * 29 + 3), 1'b0, 1'b0);
        for (int k = 0; k < 6; k++)
            access(1'b0, 13'(k * 1111), 8'h00, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule